// File: doc/BRIEF.md
# Programmable User Sync Generator

This block drives one user-defined timing strobe for a video raster. It takes the current pixel and line counts from an external raster counter. It forms a horizontal window from a programmed start/stop pixel pair and a vertical window from a programmed start/stop line pair. The two windows are merged by a logical operator chosen in a control word, and the result leaves the block with a programmable polarity.

Software writes five registers through a simple write strobe and reads them back through a combinational read port. The writes land in shadow registers. The working copy is refreshed at the start of every line, which is the clock in which the pixel count is zero, so a strobe never changes shape partway through a line. The output is registered on the pixel clock.

Top module: `user_sync_gen`

## Requirements
- R1: The horizontal window is active while hstart <= pix_cnt < hstop. Register address 0 holds hstart and address 1 holds hstop.
- R2: The vertical window is active while vstart <= line_cnt < vstop. Address 2 holds vstart and address 3 holds vstop.
- R3: When control bit 2 is 1, the merged window is horizontal AND vertical, and bits 1 and 0 have no effect.
- R4: When control bit 2 is 0 and bit 1 is 1, the merged window is horizontal OR vertical, and bit 0 has no effect.
- R5: When only control bit 0 of bits 2..0 is set, the merged window is horizontal XOR vertical.
- R6: When control bits 2..0 are all 0, the merged window equals the horizontal window.
- R7: Control bit 3 sets the polarity. When it is 1, sync_o is the inverse of the merged window (active low). When it is 0, sync_o equals the merged window. The output is 1 during and just after reset.
- R8: If a start value is not below its stop value, that window is never active.
- R9: sync_o shows, one clock later, the result for the pix_cnt and line_cnt present at a rising edge.
- R10: Register writes take effect from the clock in which pix_cnt is 0. While pix_cnt is nonzero, the configuration in use stays unchanged.
- R11: The control word lives at address 4. Its bits 15..4 are ignored on write and read back as 0. Addresses 5 to 7 read as 0.
- R12: After reset the four count registers read 0 and the control word reads 0x0008.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_cnt | input | CNT_W | Current pixel count in the line |
| line_cnt | input | CNT_W | Current line count in the frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| sync_o | output | 1 | Combined user sync output |

## Verification
A 16-pixel by 8-line raster is swept point by point for all sixteen control values under four window shapes. The shapes are an interior rectangle, a window covering the full line, and two pairs with start at or above stop. The interior rectangle separates the four operators and the two polarities at every corner of the windows. The full-line window places the stop on the line length. The inverted pairs show that an empty window stays dark under every operator. A separate sequence writes a new control word in the middle of a line and checks that the old behaviour holds until pixel zero. Readback checks cover the reset values and the masking of the reserved control bits.

// File: rtl/user_sync_gen.sv
module user_sync_gen #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  pix_cnt,
  input  logic [CNT_W-1:0]  line_cnt,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sync_o
);
  localparam int PAD_C = DATA_W - CNT_W;
  localparam int PAD_K = DATA_W - 4;

  logic [CNT_W-1:0] hs_sh, he_sh, vs_sh, ve_sh;
  logic [CNT_W-1:0] hs_a,  he_a,  vs_a,  ve_a;
  logic [3:0]       ctl_sh, ctl_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_sh  <= '0;
      he_sh  <= '0;
      vs_sh  <= '0;
      ve_sh  <= '0;
      ctl_sh <= 4'h8;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: hs_sh  <= wr_data[CNT_W-1:0];
        3'd1: he_sh  <= wr_data[CNT_W-1:0];
        3'd2: vs_sh  <= wr_data[CNT_W-1:0];
        3'd3: ve_sh  <= wr_data[CNT_W-1:0];
        3'd4: ctl_sh <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  wire line_start = (pix_cnt == '0);

  wire [CNT_W-1:0] hs_e  = line_start ? hs_sh  : hs_a;
  wire [CNT_W-1:0] he_e  = line_start ? he_sh  : he_a;
  wire [CNT_W-1:0] vs_e  = line_start ? vs_sh  : vs_a;
  wire [CNT_W-1:0] ve_e  = line_start ? ve_sh  : ve_a;
  wire [3:0]       ctl_e = line_start ? ctl_sh : ctl_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_a  <= '0;
      he_a  <= '0;
      vs_a  <= '0;
      ve_a  <= '0;
      ctl_a <= 4'h8;
    end else if (line_start) begin
      hs_a  <= hs_sh;
      he_a  <= he_sh;
      vs_a  <= vs_sh;
      ve_a  <= ve_sh;
      ctl_a <= ctl_sh;
    end
  end

  wire h_act = (pix_cnt  >= hs_e) && (pix_cnt  < he_e);
  wire v_act = (line_cnt >= vs_e) && (line_cnt < ve_e);

  logic win;
  always_comb begin
    if (ctl_e[2])      win = h_act & v_act;
    else if (ctl_e[1]) win = h_act | v_act;
    else if (ctl_e[0]) win = h_act ^ v_act;
    else               win = h_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_o <= 1'b1;
    else        sync_o <= ctl_e[3] ? ~win : win;
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {{PAD_C{1'b0}}, hs_sh};
      3'd1:    rd_data = {{PAD_C{1'b0}}, he_sh};
      3'd2:    rd_data = {{PAD_C{1'b0}}, vs_sh};
      3'd3:    rd_data = {{PAD_C{1'b0}}, ve_sh};
      3'd4:    rd_data = {{PAD_K{1'b0}}, ctl_sh};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/user_sync_gen_chk.sv
module user_sync_gen_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  pix_cnt,
  input logic [CNT_W-1:0]  hs_e,
  input logic [CNT_W-1:0]  he_e,
  input logic [3:0]        ctl_e,
  input logic [3:0]        ctl_a,
  input logic              h_act,
  input logic              v_act,
  input logic [2:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sync_o
);
  assert_and_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_e[2] && !(h_act && v_act)) |=> (sync_o == $past(ctl_e[3])));

  assert_or_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_e[2] && ctl_e[1] && (h_act || v_act)) |=> (sync_o != $past(ctl_e[3])));

  assert_xor_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_e[2:0] == 3'b001) && h_act && v_act) |=> (sync_o == $past(ctl_e[3])));

  assert_empty_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_e >= he_e) |-> !h_act);

  assert_hold_midline_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != '0) |=> $stable(ctl_a));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd4) |-> (rd_data[DATA_W-1:4] == '0));
endmodule

bind user_sync_gen user_sync_gen_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .hs_e(hs_e), .he_e(he_e),
  .ctl_e(ctl_e), .ctl_a(ctl_a), .h_act(h_act), .v_act(v_act),
  .rd_addr(rd_addr), .rd_data(rd_data), .sync_o(sync_o)
);

// File: tb/user_sync_gen_bench.sv
module user_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int DATA_W = 16;
  localparam int NPIX = 16;
  localparam int NLINE = 8;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] pix_cnt = '0, line_cnt = '0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic sync_o;

  int checks = 0, errors = 0;

  int m_hs_sh, m_he_sh, m_vs_sh, m_ve_sh, m_hs_a, m_he_a, m_vs_a, m_ve_a;
  logic [3:0] m_c_sh, m_c_a;

  user_sync_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_user_sync_gen (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sync_o(sync_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_out(int p, int l, int hs, int he, int vs, int ve, logic [3:0] c);
    logic h, v, w;
    h = (p >= hs) && (p < he);
    v = (l >= vs) && (l < ve);
    if (c[2])      w = h & v;
    else if (c[1]) w = h | v;
    else if (c[0]) w = h ^ v;
    else           w = h;
    return c[3] ? ~w : w;
  endfunction

  function automatic string op_tag(logic [3:0] c);
    if (c[2]) return "R3";
    if (c[1]) return "R4";
    if (c[0]) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R1 R2 R7 R9: inputs applied before an edge appear at sync_o after it
  task automatic step(int p, int l, string tag);
    logic e;
    logic [3:0] c;
    @(negedge clk);
    pix_cnt = p[CNT_W-1:0];
    line_cnt = l[CNT_W-1:0];
    if (p == 0) begin
      m_hs_a = m_hs_sh; m_he_a = m_he_sh; m_vs_a = m_vs_sh; m_ve_a = m_ve_sh; m_c_a = m_c_sh;
    end
    c = m_c_a;
    e = exp_out(p, l, m_hs_a, m_he_a, m_vs_a, m_ve_a, c);
    @(posedge clk);
    #1;
    check((tag == "") ? op_tag(c) : tag, {15'd0, sync_o}, {15'd0, e});
  endtask

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    pix_cnt = 1;
    wr_en = 1; wr_addr = a[2:0]; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 0;
    case (a)
      0: m_hs_sh = int'(d[CNT_W-1:0]);
      1: m_he_sh = int'(d[CNT_W-1:0]);
      2: m_vs_sh = int'(d[CNT_W-1:0]);
      3: m_ve_sh = int'(d[CNT_W-1:0]);
      4: m_c_sh = d[3:0];
      default: ;
    endcase
  endtask

  task automatic rd_check(int a, logic [DATA_W-1:0] exp, string tag);
    rd_addr = a[2:0];
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic config_regs(int hs, int he, int vs, int ve, logic [3:0] c);
    wr(0, hs[DATA_W-1:0]);
    wr(1, he[DATA_W-1:0]);
    wr(2, vs[DATA_W-1:0]);
    wr(3, ve[DATA_W-1:0]);
    wr(4, {12'd0, c});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hs, he, vs, ve;
    string tag;
    m_hs_sh = 0; m_he_sh = 0; m_vs_sh = 0; m_ve_sh = 0;
    m_hs_a = 0; m_he_a = 0; m_vs_a = 0; m_ve_a = 0;
    m_c_sh = 4'h8; m_c_a = 4'h8;
    #(CLK_PERIOD * 3);
    check("R7", {15'd0, sync_o}, 16'd1);
    rst_n = 1;
    #(CLK_PERIOD);
    // R12 reset values
    for (int a = 0; a < 4; a++) rd_check(a, 16'h0000, "R12");
    rd_check(4, 16'h0008, "R12");
    step(0, 0, "R7");

    // R11 reserved bits
    wr(4, 16'hFFF5);
    rd_check(4, 16'h0005, "R11");
    rd_check(5, 16'h0000, "R11");
    rd_check(7, 16'h0000, "R11");
    wr(4, 16'h0008);

    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin hs = 3;  he = 10; vs = 2; ve = 6; end
        1: begin hs = 0;  he = NPIX; vs = 0; ve = 1; end
        2: begin hs = 9;  he = 9;  vs = 6; ve = 2; end
        default: begin hs = 12; he = 5; vs = 0; ve = NLINE; end
      endcase
      tag = (k >= 2) ? "R8" : "";
      for (int c = 0; c < 16; c++) begin
        config_regs(hs, he, vs, ve, c[3:0]);
        for (int l = 0; l < NLINE; l++)
          for (int p = 0; p < NPIX; p++)
            step(p, l, tag);
      end
    end

    // R10 mid-line write waits for pixel zero
    config_regs(3, 10, 0, NLINE, 4'h0);
    step(0, 1, "R10");
    step(5, 1, "R10");
    wr(4, 16'h0008);
    step(6, 1, "R10");
    check("R10", {15'd0, sync_o}, 16'd1);
    step(7, 1, "R10");
    check("R10", {15'd0, sync_o}, 16'd1);
    step(0, 2, "R10");
    check("R10", {15'd0, sync_o}, 16'd1);
    step(4, 2, "R10");
    check("R10", {15'd0, sync_o}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule